// File: doc/BRIEF.md
# Two-wire register file controller

This block is the register-access layer that sits behind a two-wire serial slave. The bus-level slave handles start, stop and acknowledge, and hands this block decoded byte events. A write event is flagged either as the address phase (the first byte after the device address) or as a data byte. A read event asks for the next register byte. The block keeps the current register pointer and stores writes into the register map. It captures read data and steps the pointer after each data access. Setting the top bit of the address byte holds the pointer in place.

The map has read-only monitor registers at the bottom, fed from inputs. A bank of writable control registers follows them. A read-only identification byte sits at address 126 and the configuration register at address 127. The configuration register is reset only by the hardware reset, and its MSB selects normal operation (1) or power save (0). Bit 0 of the first control register requests a soft reset. The bit clears itself and raises a one-cycle pulse that returns every control register, but not the configuration register, to its default.

Top module: `twowire_regfile`

## Requirements
- R1: A write event flagged as address phase loads the pointer with bits 6:0 of the byte. Each later data write stores the byte at the pointer and then advances the pointer by one.
- R2: When bit 7 of the last address byte was 1, data writes and reads leave the pointer unchanged, so one register is accessed repeatedly.
- R3: The pointer advances from 127 to 0.
- R4: A read event captures the register at the pointer into rdData, visible from the next cycle and held until the next read. The pointer advances as in R1 and R2.
- R5: Addresses 0 to MonCount-1 (0 to 6) read byte i of monitorBus (bits 8i+7:8i). Writes to them are ignored.
- R6: Address 126 reads the identification value ChipId (default 8'hA5). Writes to it are ignored.
- R7: Addresses that are not implemented (NumCtrl+MonCount to 125, default 15 to 125) read 8'h00, and writes to them are ignored.
- R8: After hardware reset, control register i (address MonCount+i) holds 8'h10+i and is visible on ctrlRegs bits 8i+7:8i. The configuration register holds 8'h00, powerSave is 1, and rdData and softResetPulse are 0.
- R9: A write to address 127 stores the byte. powerSave is the inverse of its bit 7 from the next cycle.
- R10: A data write to address MonCount (7) with bit 0 set raises softResetPulse for exactly the next cycle. Bit 0 of that register always reads 0, and its bits 7:1 store normally.
- R11: At the end of the pulse cycle every control register returns to its R8 default. The configuration register and powerSave keep their values.
- R12: A write to a control register during the pulse cycle is lost: the default wins. A read during the pulse cycle returns the value held before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, resets everything including configuration |
| evWrite | input | 1 | One-cycle write byte event |
| evAddrPhase | input | 1 | Qualifies evWrite: byte is the register address byte |
| evData | input | 8 | Byte carried by a write event |
| evRead | input | 1 | One-cycle read byte event |
| monitorBus | input | MonCount*8 | Values of the read-only monitor registers |
| rdData | output | 8 | Captured read byte |
| powerSave | output | 1 | 1 while the configuration MSB is 0 |
| softResetPulse | output | 1 | One-cycle soft reset of the control registers |
| ctrlRegs | output | NumCtrl*8 | Contents of the control registers |

## Verification
The soft-reset pulse and a data access can fall in the same cycle. The pulse lands in the cycle right after the trigger write, and a back-to-back data byte, or a read to a control register, lands there too. The bench provokes this directly by writing the trigger byte and then immediately writing the next control register, and again at random because random data bytes often hit address 7 with bit 0 set. Its model applies the reset after reading pre-edge values and drops control writes made in the pulse cycle. Every later read and every ctrlRegs snapshot then shows whether the reset won over the write and whether the read captured the old value.

// File: rtl/twowire_regfile_pkg.sv
package twowire_regfile_pkg;

  localparam int AddrW = 7;
  localparam int ByteW = 8;
  localparam logic [AddrW-1:0] CfgAddr = 7'd127;
  localparam logic [AddrW-1:0] IdAddr  = 7'd126;
  localparam int SoftIdx = 0;
  localparam int SoftBit = 0;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [AddrW-1:0] addr;
    logic [ByteW-1:0] data;
  } accessStrobeT;

  function automatic logic [ByteW-1:0] ctrlDefault(input int idx);
    return 8'h10 + 8'(idx);
  endfunction

endpackage

// File: rtl/twowire_access_ctrl.sv
module twowire_access_ctrl
  import twowire_regfile_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             evWrite,
  input  logic             evAddrPhase,
  input  logic [ByteW-1:0] evData,
  input  logic             evRead,
  output accessStrobeT     strobe
);

  logic [AddrW-1:0] ptrQ;
  logic             inhibitQ;
  logic             addrLoad;
  logic             dataStep;

  assign addrLoad = evWrite && evAddrPhase;
  assign dataStep = strobe.wrEn || strobe.rdEn;

  always_comb begin
    strobe.wrEn = evWrite && !evAddrPhase;
    strobe.rdEn = evRead && !evWrite;
    strobe.addr = ptrQ;
    strobe.data = evData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ     <= '0;
      inhibitQ <= 1'b0;
    end else if (addrLoad) begin
      ptrQ     <= evData[AddrW-1:0];
      inhibitQ <= evData[ByteW-1];
    end else if (dataStep && !inhibitQ) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  // R1: a data access steps the pointer by one
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (dataStep && !addrLoad && !inhibitQ && ptrQ != CfgAddr) |=> ptrQ == $past(ptrQ) + 7'd1);

  // R2: the inhibit bit holds the pointer
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataStep && !addrLoad && inhibitQ) |=> $stable(ptrQ));

  // R3: stepping past the top wraps to zero
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataStep && !addrLoad && !inhibitQ && ptrQ == CfgAddr) |=> ptrQ == '0);

  // R1: an address byte loads the pointer
  p_ptr_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |=> ptrQ == $past(evData[AddrW-1:0]));

endmodule

// File: rtl/twowire_reg_datapath.sv
module twowire_reg_datapath
  import twowire_regfile_pkg::*;
#(
  parameter int              MonCount   = 7,
  parameter int              NumCtrl    = 8,
  parameter logic [ByteW-1:0] ChipId    = 8'hA5,
  parameter logic [ByteW-1:0] CfgDefault = 8'h00
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  accessStrobeT              strobe,
  input  logic [MonCount*ByteW-1:0] monitorBus,
  output logic [ByteW-1:0]          rdData,
  output logic                      powerSave,
  output logic                      softResetPulse,
  output logic [NumCtrl*ByteW-1:0]  ctrlRegs
);

  localparam int CtrlBase = MonCount;
  localparam logic [AddrW-1:0] SoftAddr = 7'(CtrlBase + SoftIdx);

  logic [NumCtrl-1:0][ByteW-1:0] ctrlQ;
  logic [ByteW-1:0]              cfgQ;
  logic [ByteW-1:0]              readMux;
  logic                          softTrigger;
  logic                          cfgHit;

  assign softTrigger = strobe.wrEn && strobe.addr == SoftAddr &&
                       strobe.data[SoftBit] && !softResetPulse;
  assign cfgHit      = strobe.wrEn && strobe.addr == CfgAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) softResetPulse <= 1'b0;
    else       softResetPulse <= softTrigger;
  end

  for (genvar i = 0; i < NumCtrl; i++) begin : g_ctrl
    localparam logic [AddrW-1:0] RegAddr = 7'(CtrlBase + i);
    localparam logic [ByteW-1:0] RegDef  = ctrlDefault(i);
    logic regHit;
    assign regHit = strobe.wrEn && strobe.addr == RegAddr;

    if (i == SoftIdx) begin : g_soft
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               ctrlQ[i] <= RegDef;
        else if (softResetPulse) ctrlQ[i] <= RegDef;
        else if (regHit) begin
          ctrlQ[i]          <= strobe.data;
          ctrlQ[i][SoftBit] <= 1'b0;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               ctrlQ[i] <= RegDef;
        else if (softResetPulse) ctrlQ[i] <= RegDef;
        else if (regHit)         ctrlQ[i] <= strobe.data;
      end
    end

    // R11: the pulse returns each control register to its default
    p_ctrl_default_r11: assert property (@(posedge clk) disable iff (!rstN)
      softResetPulse |=> ctrlQ[i] == RegDef);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cfgQ <= CfgDefault;
    else if (cfgHit) cfgQ <= strobe.data;
  end

  assign powerSave = !cfgQ[ByteW-1];
  assign ctrlRegs  = ctrlQ;

  always_comb begin
    readMux = '0;
    for (int m = 0; m < MonCount; m++)
      if (strobe.addr == 7'(m)) readMux = monitorBus[m*ByteW +: ByteW];
    for (int c = 0; c < NumCtrl; c++)
      if (strobe.addr == 7'(CtrlBase + c)) readMux = ctrlQ[c];
    if (strobe.addr == IdAddr)  readMux = ChipId;
    if (strobe.addr == CfgAddr) readMux = cfgQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= readMux;
  end

  // R10: the soft reset pulse lasts a single cycle
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    softResetPulse |=> !softResetPulse);

  // R11: configuration survives the pulse when not written
  p_cfg_keep_r11: assert property (@(posedge clk) disable iff (!rstN)
    (softResetPulse && !cfgHit) |=> $stable(cfgQ) && $stable(powerSave));

  // R9: power save follows the written MSB
  p_power_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgHit |=> powerSave == !$past(strobe.data[ByteW-1]));

  // R4: read data only changes on a read event
  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdData));

endmodule

// File: rtl/twowire_regfile.sv
module twowire_regfile
  import twowire_regfile_pkg::*;
#(
  parameter int              MonCount   = 7,
  parameter int              NumCtrl    = 8,
  parameter logic [7:0]      ChipId     = 8'hA5,
  parameter logic [7:0]      CfgDefault = 8'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  evWrite,
  input  logic                  evAddrPhase,
  input  logic [7:0]            evData,
  input  logic                  evRead,
  input  logic [MonCount*8-1:0] monitorBus,
  output logic [7:0]            rdData,
  output logic                  powerSave,
  output logic                  softResetPulse,
  output logic [NumCtrl*8-1:0]  ctrlRegs
);

  accessStrobeT strobe;

  twowire_access_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evWrite     (evWrite),
    .evAddrPhase (evAddrPhase),
    .evData      (evData),
    .evRead      (evRead),
    .strobe      (strobe)
  );

  twowire_reg_datapath #(
    .MonCount   (MonCount),
    .NumCtrl    (NumCtrl),
    .ChipId     (ChipId),
    .CfgDefault (CfgDefault)
  ) u_data (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .monitorBus     (monitorBus),
    .rdData         (rdData),
    .powerSave      (powerSave),
    .softResetPulse (softResetPulse),
    .ctrlRegs       (ctrlRegs)
  );

endmodule

// File: tb/test_twowire_regfile.sv
module test_twowire_regfile;

  localparam int MonCount = 7;
  localparam int NumCtrl  = 8;
  localparam logic [7:0] ChipId = 8'hA5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, evWrite, evAddrPhase, evRead;
  logic [7:0] evData;
  logic [MonCount*8-1:0] monitorBus;
  logic [7:0] rdData;
  logic powerSave, softResetPulse;
  logic [NumCtrl*8-1:0] ctrlRegs;

  twowire_regfile i_twowire_regfile (
    .clk(clk), .rstN(rstN), .evWrite(evWrite), .evAddrPhase(evAddrPhase),
    .evData(evData), .evRead(evRead), .monitorBus(monitorBus),
    .rdData(rdData), .powerSave(powerSave), .softResetPulse(softResetPulse),
    .ctrlRegs(ctrlRegs)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] mMon [MonCount];
  logic [7:0] mCtrl [NumCtrl];
  logic [7:0] mCfg;
  logic [7:0] mRd;
  logic [6:0] mPtr;
  bit mInh, mPend;

  function automatic logic [7:0] ctrlDef(int i);
    return 8'h10 + 8'(i);
  endfunction

  function automatic logic [7:0] modelRead(logic [6:0] a);
    if (int'(a) < MonCount) return mMon[a];
    if (int'(a) < MonCount + NumCtrl) return mCtrl[int'(a) - MonCount];
    if (a == 7'd126) return ChipId;
    if (a == 7'd127) return mCfg;
    return 8'h00;
  endfunction

  function automatic logic [NumCtrl*8-1:0] modelCtrlVec();
    logic [NumCtrl*8-1:0] v;
    for (int i = 0; i < NumCtrl; i++) v[i*8 +: 8] = mCtrl[i];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit doWr, bit isAddr, logic [7:0] d, bit doRd);
    bit newPend;
    int a;
    @(negedge clk);
    evWrite = doWr; evAddrPhase = isAddr; evData = d; evRead = doRd;
    if (doRd) mRd = modelRead(mPtr);
    if (mPend) for (int i = 0; i < NumCtrl; i++) mCtrl[i] = ctrlDef(i);
    newPend = 1'b0;
    if (doWr && isAddr) begin
      mPtr = d[6:0];
      mInh = d[7];
    end else if (doWr) begin
      a = int'(mPtr);
      if (a == 127) mCfg = d;
      else if (a >= MonCount && a < MonCount + NumCtrl && !mPend) begin
        if (a == MonCount) begin
          mCtrl[0] = {d[7:1], 1'b0};
          if (d[0]) newPend = 1'b1;
        end else mCtrl[a - MonCount] = d;
      end
      if (!mInh) mPtr = mPtr + 7'd1;
    end else if (doRd) begin
      if (!mInh) mPtr = mPtr + 7'd1;
    end
    mPend = newPend;
    @(posedge clk);
    #1;
    evWrite = 1'b0; evAddrPhase = 1'b0; evRead = 1'b0; evData = 8'h00;
    chk(rdData == mRd, "R4 rdData", rdData, mRd);
    chk(powerSave == !mCfg[7], "R9 powerSave", powerSave, !mCfg[7]);
    chk(softResetPulse == mPend, "R10 softResetPulse", softResetPulse, mPend);
    chk(ctrlRegs == modelCtrlVec(), "R11 ctrlRegs", ctrlRegs, modelCtrlVec());
  endtask

  task automatic wrA(logic [7:0] d); step(1'b1, 1'b1, d, 1'b0); endtask
  task automatic wrD(logic [7:0] d); step(1'b1, 1'b0, d, 1'b0); endtask
  task automatic rdB();              step(1'b0, 1'b0, 8'h00, 1'b1); endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; evWrite = 1'b0; evAddrPhase = 1'b0; evRead = 1'b0; evData = 8'h00;
    for (int i = 0; i < MonCount; i++) begin
      mMon[i] = 8'($urandom);
      monitorBus[i*8 +: 8] = mMon[i];
    end
    for (int i = 0; i < NumCtrl; i++) mCtrl[i] = ctrlDef(i);
    mCfg = 8'h00; mRd = 8'h00; mPtr = 7'd0; mInh = 1'b0; mPend = 1'b0;
    repeat (3) @(negedge clk);
    chk(powerSave == 1'b1, "R8 powerSave after reset", powerSave, 1);
    chk(softResetPulse == 1'b0, "R8 pulse after reset", softResetPulse, 0);
    chk(rdData == 8'h00, "R8 rdData after reset", rdData, 0);
    chk(ctrlRegs == modelCtrlVec(), "R8 control defaults", ctrlRegs, modelCtrlVec());
    rstN = 1'b1;

    // R9 leave power save, then R3 wrap to 0 and R5 monitor read
    wrA(8'h7F); wrD(8'h80);
    chk(powerSave == 1'b0, "R9 leave power save", powerSave, 0);
    rdB();
    chk(rdData == mMon[0], "R3 wrap then read monitor 0 (R5)", rdData, mMon[0]);

    // R6 identification ignores writes
    wrA(8'h7E); wrD(8'h33); wrA(8'h7E); rdB();
    chk(rdData == ChipId, "R6 chip id", rdData, ChipId);

    // R2 repeated read of one monitor
    wrA(8'h82); rdB(); rdB(); rdB();
    chk(rdData == mMon[2], "R2 repeated read", rdData, mMon[2]);
    // R2 repeated write to one control register
    wrA(8'h89); wrD(8'h11); wrD(8'h22); wrA(8'h09); rdB();
    chk(rdData == 8'h22, "R2 repeated write", rdData, 8'h22);
    rdB();
    chk(rdData == ctrlDef(3), "R1 next register untouched", rdData, ctrlDef(3));

    // R5 monitor write ignored
    wrA(8'h03); wrD(8'hFF); wrA(8'h03); rdB();
    chk(rdData == mMon[3], "R5 monitor write ignored", rdData, mMon[3]);

    // R7 unimplemented
    wrA(8'd50); wrD(8'h77); wrA(8'd50); rdB();
    chk(rdData == 8'h00, "R7 unimplemented reads zero", rdData, 0);

    // R10/R11/R12 soft reset with a back-to-back write
    wrA(8'h08); wrD(8'h99);
    wrA(8'h07); wrD(8'h03);
    chk(softResetPulse == 1'b1, "R10 pulse raised", softResetPulse, 1);
    chk(ctrlRegs[7:0] == 8'h02, "R10 trigger bit reads 0", ctrlRegs[7:0], 8'h02);
    wrD(8'h44);
    chk(softResetPulse == 1'b0, "R10 pulse single cycle", softResetPulse, 0);
    chk(ctrlRegs[15:8] == ctrlDef(1), "R12 reset wins over write", ctrlRegs[15:8], ctrlDef(1));
    chk(powerSave == 1'b0, "R11 config kept", powerSave, 0);

    // R12 read in the pulse cycle returns the old value
    wrA(8'h08); wrD(8'h5A);
    wrA(8'h87); wrD(8'h01); rdB();
    chk(rdData == 8'h00, "R12 read during pulse returns old value", rdData, 8'h00);
    wrA(8'h07); rdB(); rdB();
    chk(rdData == ctrlDef(1), "R11 register back to default", rdData, ctrlDef(1));

    // R9 re-enter power save
    wrA(8'h7F); wrD(8'h00);
    chk(powerSave == 1'b1, "R9 re-enter power save", powerSave, 1);

    // R4 sequential reads
    wrA(8'h07); rdB(); rdB(); rdB();
    chk(rdData == ctrlDef(2), "R4 sequential read", rdData, ctrlDef(2));

    for (int n = 0; n < 600; n++) begin
      int r;
      logic [7:0] ab;
      r = int'($urandom % 8);
      if (r < 2) begin
        ab = ($urandom % 2 == 0) ? 8'($urandom % 18) : 8'(120 + $urandom % 8);
        if ($urandom % 4 == 0) ab[7] = 1'b1;
        wrA(ab);
      end else if (r < 5) wrD(8'($urandom));
      else if (r < 7) rdB();
      else step(1'b0, 1'b0, 8'h00, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule